// File: doc/BRIEF.md
# Two-Rank Shaft Angle Input Register

This block takes a 16-bit natural binary shaft angle from a host bus and holds it for a converter. The host bus may be 8 or 16 bits wide. The register has two ranks. The first rank is split into an upper byte and a lower byte, and each byte has its own load enable. A host on a byte-wide bus can therefore stage the two halves one at a time. A separate transfer enable then copies both halves into the second rank in one clock. The second rank drives the converter. As a result the angle seen downstream never shows a half-written value.

The block is synchronous: all enables are sampled on the system clock. A byte register follows its data lines on every clock while its enable is high. When the enable drops, the register keeps the value it took at the last clock with the enable high. If the transfer enable and a byte enable are high in the same cycle, the incoming byte goes straight through to the output in that clock.

The host interface has timing limits for minimum enable width and for data setup and hold around the end of a byte load. In this model those limits are counts of clock cycles. The block checks them and reports any violation on a one-cycle flag. It also gives a one-cycle flag when the output angle takes a new value.

Top module: `shaft_angle_latch`

## Requirements
- R1: While reset is held, and after it is released, `angle`, `angle_new` and `tmg_err` are all 0. An angle of 0 means 0 degrees.
- R2: `din[15:8]` is the most significant byte of the angle. At each clock where `ld_hi` is 1, the upper staging byte takes `din[15:8]`. At each clock where `ld_lo` is 1, the lower staging byte takes `din[7:0]`. Each byte keeps its last loaded value while its enable is 0.
- R3: Loading either staging byte while `ld_all` is 0 never changes `angle` and never raises `angle_new`.
- R4: At each clock where `ld_all` is 1, `angle` takes the full 16-bit staged word in that same edge. While `ld_all` is 0, `angle` holds its value.
- R5: When `ld_all` and a byte enable are both 1 at the same clock, the matching byte of `angle` takes the current `din` byte at that edge, not the byte that was staged before.
- R6: `angle_new` is 1 for exactly the one cycle in which `angle` first shows a value that differs from its previous value. It is 0 when a transfer writes the same value again.
- R7: When any enable falls after it was high for fewer than MIN_PULSE consecutive clocks, `tmg_err` is 1 for one cycle, in the cycle after the first clock at which the enable is seen low.
- R8: When a byte enable falls and the matching `din` byte was not constant for at least SETUP clocks ending at the last clock with the enable high, `tmg_err` is 1 for one cycle, in the cycle after the clock at which the fall is seen.
- R9: When the matching `din` byte changes within HOLD clocks after the last clock at which a byte enable was high, `tmg_err` is 1 for one cycle. This happens in the cycle after the HOLD-th clock following that last high clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 16 | Angle data lines, bit 15 = MSB |
| ld_hi | input | 1 | Upper staging byte load enable, active high |
| ld_lo | input | 1 | Lower staging byte load enable, active high |
| ld_all | input | 1 | Transfer enable from staging to output rank, active high |
| angle | output | 16 | Held output angle word |
| angle_new | output | 1 | One-cycle pulse when `angle` changes |
| tmg_err | output | 1 | One-cycle pulse on an enable width, setup or hold violation |

## Verification
The hardest case to reach is the hold check. The hold check looks at the data several clocks after the enable has dropped. By that time the enable can no longer show anything, so the violation appears only through a delayed error pulse. The stimulus reaches it with a directed write that is correct up to the fall of the enable and then changes the data byte one clock later. The expected single error pulse is counted over the whole window.

Flow-through is the other hard case. The same-cycle interaction of transfer and byte load is reached by raising both enables together, with data that differs from the staged byte.

Random byte writes and transfers, all with correct timing, check that the output changes only on a transfer. They also check that no false timing error appears.

// File: rtl/shaft_angle_latch.sv
module shaft_angle_latch #(
  parameter int MIN_PULSE = 10,
  parameter int SETUP     = 5,
  parameter int HOLD      = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] din,
  input  logic        ld_hi,
  input  logic        ld_lo,
  input  logic        ld_all,
  output logic [15:0] angle,
  output logic        angle_new,
  output logic        tmg_err
);
  localparam int LIM0 = (MIN_PULSE > SETUP) ? MIN_PULSE : SETUP;
  localparam int LIM  = (LIM0 > HOLD + 1) ? LIM0 : HOLD + 1;
  localparam int CW   = $clog2(LIM + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIM);

  logic [7:0]  hi_q, lo_q;
  logic [15:0] angle_q;
  logic        new_q, err_q;
  logic [2:0]  en, en_d, fall, viol_w;
  logic [1:0]  viol_s, viol_h;

  wire [7:0]  hi_nx = ld_hi ? din[15:8] : hi_q;
  wire [7:0]  lo_nx = ld_lo ? din[7:0]  : lo_q;
  wire [15:0] xfer  = {hi_nx, lo_nx};

  assign en        = {ld_all, ld_hi, ld_lo};
  assign fall      = en_d & ~en;
  assign angle     = angle_q;
  assign angle_new = new_q;
  assign tmg_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      angle_q <= '0;
      new_q   <= 1'b0;
      err_q   <= 1'b0;
      en_d    <= '0;
    end else begin
      hi_q  <= hi_nx;
      lo_q  <= lo_nx;
      if (ld_all) angle_q <= xfer;
      new_q <= ld_all && (xfer != angle_q);
      err_q <= |{viol_w, viol_s, viol_h};
      en_d  <= en;
    end
  end

  for (genvar j = 0; j < 3; j++) begin : g_width
    logic [CW-1:0] wcnt;
    always_ff @(posedge clk) begin
      if (!rst_n)       wcnt <= '0;
      else if (!en[j])  wcnt <= '0;
      else if (wcnt != CMAX) wcnt <= wcnt + 1'b1;
    end
    assign viol_w[j] = fall[j] && (int'(wcnt) < MIN_PULSE);
  end

  for (genvar i = 0; i < 2; i++) begin : g_lane
    logic [7:0]    byte_d;
    logic [CW-1:0] run_q, run_now, hcnt;
    logic          chk;
    wire  [7:0]    cur = din[8*i +: 8];

    assign run_now = (cur != byte_d) ? CW'(1) :
                     (run_q == CMAX) ? CMAX : run_q + 1'b1;
    assign chk     = (fall[i] && HOLD == 1) || (hcnt == CW'(1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        byte_d <= '0;
        run_q  <= '0;
        hcnt   <= '0;
      end else begin
        byte_d <= cur;
        run_q  <= run_now;
        if (fall[i])         hcnt <= CW'(HOLD - 1);
        else if (hcnt != '0) hcnt <= hcnt - 1'b1;
      end
    end

    assign viol_s[i] = fall[i] && (int'(run_q) < SETUP);
    assign viol_h[i] = chk && (int'(run_now) < HOLD + 1);
  end
endmodule

// File: rtl/shaft_angle_latch_chk.sv
module shaft_angle_latch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] din,
  input logic        ld_hi,
  input logic        ld_lo,
  input logic        ld_all,
  input logic [15:0] angle,
  input logic        angle_new,
  input logic        tmg_err
);
  AST_HOLD_WITHOUT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_all |=> $stable(angle)); // R4
  AST_BYTE_ONLY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_all && (ld_hi || ld_lo)) |=> !angle_new); // R3
  AST_FULL_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_all && ld_hi && ld_lo) |=> angle == $past(din)); // R4
  AST_FLOW_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_all && ld_hi) |=> angle[15:8] == $past(din[15:8])); // R5
  AST_FLOW_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_all && ld_lo) |=> angle[7:0] == $past(din[7:0])); // R5
  AST_NEW_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && angle != $past(angle)) |-> angle_new); // R6
  AST_NEW_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    angle_new |-> $past(ld_all)); // R6
  AST_SINGLE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ld_lo) && !$past(ld_lo, 2) && $past(rst_n, 2)) |=> tmg_err); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (angle == 16'h0 && !angle_new && !tmg_err)); // R1
endmodule

bind shaft_angle_latch shaft_angle_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .ld_hi(ld_hi), .ld_lo(ld_lo),
  .ld_all(ld_all), .angle(angle), .angle_new(angle_new), .tmg_err(tmg_err)
);

// File: tb/test_shaft_angle_latch.sv
module test_shaft_angle_latch;
  localparam int MP = 10, SU = 5, HD = 3;

  logic clk = 0, rst_n = 0, ld_hi = 0, ld_lo = 0, ld_all = 0;
  logic [15:0] din = '0;
  logic [15:0] angle;
  logic angle_new, tmg_err;
  int checks = 0, errors = 0, n_new = 0, n_tm = 0;
  logic [7:0] e_hi = 0, e_lo = 0;
  logic [15:0] e_ang = 0;

  always #10 clk = ~clk;

  shaft_angle_latch #(.MIN_PULSE(MP), .SETUP(SU), .HOLD(HD)) i_shaft_angle_latch (
    .clk(clk), .rst_n(rst_n), .din(din), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .ld_all(ld_all), .angle(angle), .angle_new(angle_new), .tmg_err(tmg_err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (tmg_err) n_tm++;
      if (angle_new) n_new++;
    end
  endtask

  function automatic logic [15:0] staged();
    return {e_hi, e_lo};
  endfunction

  task automatic wr(input bit hi, input logic [7:0] b, input int width = MP);
    if (hi) din[15:8] = b; else din[7:0] = b;
    tick(SU);
    if (hi) ld_hi = 1; else ld_lo = 1;
    tick(width);
    ld_hi = 0; ld_lo = 0;
    tick(HD + 1);
    if (hi) e_hi = b; else e_lo = b;
  endtask

  task automatic xfer();
    logic [15:0] exp = staged();
    int exp_new = (exp != e_ang) ? 1 : 0;
    n_new = 0;
    ld_all = 1;
    tick(1);
    chk(angle == exp, "R4 transfer", angle, exp);
    tick(MP - 1);
    ld_all = 0;
    tick(1);
    chk(n_new == exp_new, "R6 new-angle pulse count", n_new, exp_new);
    e_ang = exp;
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    tick(3);
    chk(angle == 0 && !angle_new && !tmg_err, "R1 during reset", {angle, angle_new, tmg_err}, 0);
    rst_n = 1;
    tick(2);
    chk(angle == 0 && !angle_new && !tmg_err, "R1 after reset", {angle, angle_new, tmg_err}, 0);

    // R2 and R3: byte loads leave the output alone
    n_new = 0; n_tm = 0;
    wr(1, 8'hA5);
    wr(0, 8'h3C);
    chk(angle == 0, "R3 byte loads do not reach angle", angle, 0);
    chk(n_new == 0, "R3 no pulse on byte loads", n_new, 0);
    xfer();
    chk(angle == 16'hA53C, "R2 byte placement", angle, 16'hA53C);
    // R2 transparency: the last clock with the enable high wins
    din[7:0] = 8'h11; tick(SU); ld_lo = 1; tick(4);
    din[7:0] = 8'h77; tick(SU + 2); ld_lo = 0; tick(HD + 1);
    e_lo = 8'h77;
    xfer();
    chk(angle == 16'hA577, "R2 last value held", angle, 16'hA577);
    // R6: transfer of identical value gives no pulse
    xfer();
    chk(n_tm == 0, "R7 no false timing error", n_tm, 0);

    // R5 flow-through
    din = 16'h5E00 | 16'(e_lo); n_new = 0;
    tick(SU);
    ld_all = 1; ld_hi = 1;
    tick(1);
    chk(angle == {8'h5E, e_lo}, "R5 flow-through upper", angle, {8'h5E, e_lo});
    chk(angle_new == 1, "R6 pulse aligned with change", angle_new, 1);
    tick(MP - 1);
    ld_all = 0; ld_hi = 0;
    tick(HD + 1);
    e_hi = 8'h5E; e_ang = staged();
    chk(n_new == 1, "R6 single pulse", n_new, 1);
    din[7:0] = 8'hC4; tick(SU);
    ld_all = 1; ld_lo = 1;
    tick(1);
    chk(angle == 16'h5EC4, "R5 flow-through lower", angle, 16'h5EC4);
    tick(MP - 1); ld_all = 0; ld_lo = 0; tick(HD + 1);
    e_lo = 8'hC4; e_ang = staged();

    // R7 short pulse
    n_tm = 0;
    wr(0, 8'h21, 2);
    chk(n_tm == 1, "R7 short byte enable", n_tm, 1);
    n_tm = 0; ld_all = 1; tick(1); ld_all = 0; tick(3);
    e_ang = staged();
    chk(n_tm == 1, "R7 short transfer enable", n_tm, 1);
    chk(angle == e_ang, "R4 short transfer still copies", angle, e_ang);

    // R8 setup violation: data changes just before the fall
    n_tm = 0;
    din[15:8] = 8'h10; tick(SU); ld_hi = 1; tick(MP - 1);
    din[15:8] = 8'h20; tick(1); ld_hi = 0; tick(HD + 2);
    e_hi = 8'h20;
    chk(n_tm == 1, "R8 setup violation", n_tm, 1);

    // R9 hold violation: data changes one clock after the fall
    n_tm = 0;
    din[7:0] = 8'h40; tick(SU); ld_lo = 1; tick(MP); ld_lo = 0; tick(1);
    din[7:0] = 8'h41; tick(HD + 2);
    e_lo = 8'h40;
    chk(n_tm == 1, "R9 hold violation", n_tm, 1);
    xfer();
    chk(angle == 16'h2040, "R2 captured before hold change", angle, 16'h2040);

    // random legal traffic
    n_tm = 0;
    for (int it = 0; it < 150; it++) begin
      int op = $urandom % 3;
      logic [7:0] b = 8'($urandom);
      if (op == 2) xfer();
      else begin
        n_new = 0;
        wr(op == 1, b);
        chk(angle == e_ang && n_new == 0, "R3 random byte load", angle, e_ang);
      end
    end
    chk(n_tm == 0, "R7 R8 R9 no error on legal traffic", n_tm, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule